// File: doc/BRIEF.md
# Diskette Controller Host Register Interface

This block is the byte-wide register front end that a host processor sees for a two-drive, single-density diskette controller. The host reads status, a result type and a result byte. It writes a 16-bit pointer to a parameter block in memory, and it can soft-reset the subsystem. A write to the pointer's high byte also launches a command. The block then emits a one-cycle start pulse to a separate command engine and stays busy until that engine returns a completion record.

The completion record flows from the engine into this block over a valid/ready channel. `cmp_ready` is high exactly while an operation is outstanding. The engine holds `cmp_valid` and its payload steady until it sees `cmp_ready`, and a transfer happens on the rising clock edge where both are high. While the block is idle, `cmp_ready` stays low, so any record the engine offers waits and changes nothing. The bus strobes, the drive ready inputs and the interrupt output are plain level signals. Read data is combinational while a read strobe is present; read side effects take place at the clock edge that ends the access.

Top module: `fdc_host_regs`

## Requirements
- R1: A read of offset 0 returns a status byte laid out as follows: bit 0 is drive 0 ready, bit 1 is drive 1 ready, bit 2 is the interrupt flag, bit 3 is always 1, and bits 7:4 are 0.
- R2: A read of offset 1 returns the 2-bit result type in bits 1:0, with bits 7:2 zero. At the end of that access the interrupt flag is cleared, unless a completion that requests an interrupt lands on the same edge.
- R3: While idle, a write to offset 1 replaces bits 7:0 of `iopb_ptr` and keeps bits 15:8. A write to offset 2 ORs the data into bits 15:8, raises `start_pulse` for exactly the one cycle that follows the write, and makes the block busy.
- R4: While busy, writes to offsets 1 and 2 change neither `iopb_ptr` nor `start_pulse`.
- R5: `cmp_ready` is high exactly while busy. An accepted completion does four things: it stores the result type, the error byte and the ready-changed flag; it sets the interrupt flag if `cmp_irq` is 1 and otherwise leaves it as it was; and it ends busy. An offered record is not taken while idle and has no effect.
- R6: A read of offset 3 returns the error byte when the result type is 00. For any other result type, it returns the ready byte if ready-changed is set and the error byte if it is not.
- R7: Error byte bits are as follows: 0 deleted record, 1 CRC, 2 seek, 3 address, 4 overrun/underrun, 5 write protect, 6 write error, 7 not ready. The ready byte carries drive 0 ready in bit 6 and drive 1 ready in bit 7, with bits 5:0 zero.
- R8: A write to offset 7 is accepted even while busy and performs a soft reset. It sets the result type, error byte, ready-changed flag and interrupt flag to 0, and it captures `drive_rdy` into the drive ready bits. It leaves busy and `iopb_ptr` unchanged.
- R9: Hardware reset (`rst_n` low at a clock edge) does everything a soft reset does, and it also clears `iopb_ptr` and busy.
- R10: A write to offset 3, 4, 5 or 6 has no effect. Reads of offsets 2, 4, 5, 6 and 7 return 0.
- R11: The `irq` output always equals status bit 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Register access strobe, one access per cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, zero when no read is active |
| drive_rdy | input | 2 | Per-drive ready inputs, sampled at reset |
| iopb_ptr | output | 16 | Parameter block pointer for the engine |
| start_pulse | output | 1 | One-cycle command launch |
| cmp_valid | input | 1 | Completion record offered |
| cmp_ready | output | 1 | Completion accepted (high while busy) |
| cmp_rtype | input | 2 | Completion result type |
| cmp_err | input | 8 | Completion error byte |
| cmp_rdychg | input | 1 | Completion ready-changed flag |
| cmp_irq | input | 1 | Completion requests an interrupt |
| irq | output | 1 | Level interrupt request |

## Verification
The assertions check several things on every cycle. The start pulse lasts one cycle, and every start comes with busy. The pointer cannot move while busy. Result fields change only at a completion or a reset. A result-type read clears the interrupt, and an accepted completion with an interrupt request raises it. At most one access strobe is active, and unused offsets read as zero. The bench's scenarios are needed for the rest: the read-data layouts, the result-byte selection across result types and ready-changed values, the OR-accumulation of the high pointer byte, a soft reset arriving mid-operation, and the refusal of a record that is offered while idle.

// File: rtl/fdc_regs_pkg.sv
package fdc_regs_pkg;
  localparam int ADDR_W     = 3;
  localparam int DATA_W     = 8;
  localparam int PTR_W      = 16;
  localparam int NUM_DRIVES = 2;
  localparam int RTYPE_W    = 2;

  localparam logic [ADDR_W-1:0] OFS_STATUS = 3'd0;
  localparam logic [ADDR_W-1:0] OFS_RTYPE  = 3'd1; // read: result type, write: pointer low
  localparam logic [ADDR_W-1:0] OFS_PTRHI  = 3'd2;
  localparam logic [ADDR_W-1:0] OFS_RESULT = 3'd3;
  localparam logic [ADDR_W-1:0] OFS_SRESET = 3'd7;

  localparam int STAT_INT_BIT     = 2;
  localparam int STAT_PRESENT_BIT = 3;
  localparam int RDYB_LSB         = DATA_W - NUM_DRIVES;

  localparam logic [RTYPE_W-1:0] RT_ERROR = 2'b00;

  typedef struct packed {
    logic [RTYPE_W-1:0] rtype;
    logic [DATA_W-1:0]  err;
    logic               rdychg;
    logic               irq;
  } cmp_t;
endpackage

// File: rtl/fdc_addr_decode.sv
module fdc_addr_decode
  import fdc_regs_pkg::*;
(
  input  logic              sel,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  output logic              rd_status,
  output logic              rd_rtype,
  output logic              rd_result,
  output logic              wr_ptrlo,
  output logic              wr_ptrhi,
  output logic              wr_sreset
);
  logic rd_any, wr_any;

  always_comb begin
    rd_any    = sel & ~wr;
    wr_any    = sel & wr;
    rd_status = rd_any && (addr == OFS_STATUS);
    rd_rtype  = rd_any && (addr == OFS_RTYPE);
    rd_result = rd_any && (addr == OFS_RESULT);
    wr_ptrlo  = wr_any && (addr == OFS_RTYPE);
    wr_ptrhi  = wr_any && (addr == OFS_PTRHI);
    wr_sreset = wr_any && (addr == OFS_SRESET);
  end
endmodule

// File: rtl/fdc_cmd_launch.sv
module fdc_cmd_launch
  import fdc_regs_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_ptrlo,
  input  logic              wr_ptrhi,
  input  logic [DATA_W-1:0] wdata,
  input  logic              cmp_fire,
  output logic [PTR_W-1:0]  ptr,
  output logic              busy,
  output logic              start
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr   <= '0;
      busy  <= 1'b0;
      start <= 1'b0;
    end else begin
      start <= 1'b0;
      if (!busy) begin
        if (wr_ptrlo) begin
          ptr[DATA_W-1:0] <= wdata;
        end else if (wr_ptrhi) begin
          ptr[PTR_W-1 -: DATA_W] <= ptr[PTR_W-1 -: DATA_W] | wdata;
          busy  <= 1'b1;
          start <= 1'b1;
        end
      end else if (cmp_fire) begin
        busy <= 1'b0;
      end
    end
  end

  assert_start_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> !start);
  assert_start_with_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> busy);
  assert_launch_on_hi_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ptrhi && !busy) |=> (start && busy));
  assert_ptr_frozen_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(ptr));
endmodule

// File: rtl/fdc_result_store.sv
module fdc_result_store
  import fdc_regs_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  srst,
  input  logic                  rd_rtype,
  input  logic                  cmp_fire,
  input  cmp_t                  cmp,
  input  logic [NUM_DRIVES-1:0] drive_rdy,
  output logic [RTYPE_W-1:0]    rtype,
  output logic [DATA_W-1:0]     err,
  output logic                  rdychg,
  output logic                  intff,
  output logic [NUM_DRIVES-1:0] rdy_q
);
  logic init;
  assign init = !rst_n || srst;

  always_ff @(posedge clk) begin
    if (init) begin
      rtype  <= RT_ERROR;
      err    <= '0;
      rdychg <= 1'b0;
      intff  <= 1'b0;
      rdy_q  <= drive_rdy;
    end else begin
      if (cmp_fire) begin
        rtype  <= cmp.rtype;
        err    <= cmp.err;
        rdychg <= cmp.rdychg;
      end
      if (cmp_fire && cmp.irq)
        intff <= 1'b1;
      else if (rd_rtype)
        intff <= 1'b0;
    end
  end

  assert_sreset_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    srst |=> (rtype == RT_ERROR && err == '0 && !rdychg && !intff));
  assert_rtype_read_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_rtype && !srst && !(cmp_fire && cmp.irq)) |=> !intff);
  assert_results_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!cmp_fire && !srst) |=> ($stable(rtype) && $stable(err) && $stable(rdychg)));
endmodule

// File: rtl/fdc_host_regs.sv
module fdc_host_regs
  import fdc_regs_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  bus_sel,
  input  logic                  bus_wr,
  input  logic [ADDR_W-1:0]     bus_addr,
  input  logic [DATA_W-1:0]     bus_wdata,
  output logic [DATA_W-1:0]     bus_rdata,
  input  logic [NUM_DRIVES-1:0] drive_rdy,
  output logic [PTR_W-1:0]      iopb_ptr,
  output logic                  start_pulse,
  input  logic                  cmp_valid,
  output logic                  cmp_ready,
  input  logic [RTYPE_W-1:0]    cmp_rtype,
  input  logic [DATA_W-1:0]     cmp_err,
  input  logic                  cmp_rdychg,
  input  logic                  cmp_irq,
  output logic                  irq
);
  logic rd_status, rd_rtype, rd_result, wr_ptrlo, wr_ptrhi, wr_sreset;
  logic busy, cmp_fire, intff, rdychg;
  logic [RTYPE_W-1:0]    rtype;
  logic [DATA_W-1:0]     err, status_byte, ready_byte;
  logic [NUM_DRIVES-1:0] rdy_q;
  cmp_t                  cmp;

  fdc_addr_decode u_dec (
    .sel(bus_sel), .wr(bus_wr), .addr(bus_addr),
    .rd_status(rd_status), .rd_rtype(rd_rtype), .rd_result(rd_result),
    .wr_ptrlo(wr_ptrlo), .wr_ptrhi(wr_ptrhi), .wr_sreset(wr_sreset)
  );

  assert_strobe_onehot_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rd_status, rd_rtype, rd_result, wr_ptrlo, wr_ptrhi, wr_sreset}));

  assign cmp_fire = cmp_valid && busy;
  assign cmp      = '{rtype: cmp_rtype, err: cmp_err, rdychg: cmp_rdychg, irq: cmp_irq};

  fdc_cmd_launch u_launch (
    .clk(clk), .rst_n(rst_n), .wr_ptrlo(wr_ptrlo), .wr_ptrhi(wr_ptrhi),
    .wdata(bus_wdata), .cmp_fire(cmp_fire), .ptr(iopb_ptr), .busy(busy),
    .start(start_pulse)
  );

  fdc_result_store u_res (
    .clk(clk), .rst_n(rst_n), .srst(wr_sreset), .rd_rtype(rd_rtype),
    .cmp_fire(cmp_fire), .cmp(cmp), .drive_rdy(drive_rdy), .rtype(rtype),
    .err(err), .rdychg(rdychg), .intff(intff), .rdy_q(rdy_q)
  );

  assign cmp_ready = busy;
  assign irq       = intff;

  // Per-drive ready bits appear in both the status byte and the ready byte
  for (genvar g = 0; g < NUM_DRIVES; g++) begin : g_drv
    assign status_byte[g]          = rdy_q[g];
    assign ready_byte[RDYB_LSB+g]  = rdy_q[g];
  end
  assign status_byte[STAT_INT_BIT]           = intff;
  assign status_byte[STAT_PRESENT_BIT]       = 1'b1;
  assign status_byte[DATA_W-1:STAT_PRESENT_BIT+1] = '0;
  assign ready_byte[RDYB_LSB-1:0]            = '0;

  always_comb begin
    bus_rdata = '0;
    if (rd_status)
      bus_rdata = status_byte;
    else if (rd_rtype)
      bus_rdata = {{(DATA_W-RTYPE_W){1'b0}}, rtype};
    else if (rd_result)
      bus_rdata = (rtype == RT_ERROR) ? err : (rdychg ? ready_byte : err);
  end

  assert_unused_read_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_wr && (bus_addr == 3'd2 || bus_addr > 3'd3)) |-> (bus_rdata == '0));
  assert_irq_on_done_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_valid && cmp_ready && cmp_irq && !wr_sreset) |=> irq);
  assert_idle_refuses_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (start_pulse) |-> cmp_ready);
endmodule

// File: tb/test_fdc_host_regs.sv
module test_fdc_host_regs;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0;
  logic bus_sel = 0, bus_wr = 0;
  logic [2:0] bus_addr = 0;
  logic [7:0] bus_wdata = 0, bus_rdata;
  logic [1:0] drive_rdy = 2'b01;
  logic [15:0] iopb_ptr;
  logic start_pulse, cmp_ready, irq;
  logic cmp_valid = 0, cmp_rdychg = 0, cmp_irq = 0;
  logic [1:0] cmp_rtype = 0;
  logic [7:0] cmp_err = 0;

  int total = 0, bad = 0, starts_seen = 0, starts_exp = 0;

  // reference model state
  logic [15:0] m_ptr;
  logic m_busy, m_int, m_chg;
  logic [1:0] m_rtype, m_rdy;
  logic [7:0] m_err;

  always #(CLK_PERIOD/2) clk = ~clk;

  fdc_host_regs i_fdc_host_regs (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .drive_rdy(drive_rdy), .iopb_ptr(iopb_ptr), .start_pulse(start_pulse),
    .cmp_valid(cmp_valid), .cmp_ready(cmp_ready), .cmp_rtype(cmp_rtype),
    .cmp_err(cmp_err), .cmp_rdychg(cmp_rdychg), .cmp_irq(cmp_irq), .irq(irq)
  );

  always @(posedge clk) if (rst_n && start_pulse) starts_seen++;

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_read(input logic [2:0] a);
    logic [7:0] b1 = {m_rdy[1], m_rdy[0], 6'b0};
    case (a)
      3'd0: return {4'b0, 1'b1, m_int, m_rdy};
      3'd1: return {6'b0, m_rtype};
      3'd3: return (m_rtype == 2'b00) ? m_err : (m_chg ? b1 : m_err);
      default: return 8'h00;
    endcase
  endfunction

  task automatic soft_model();
    m_rtype = 0; m_err = 0; m_chg = 0; m_int = 0; m_rdy = drive_rdy;
  endtask

  task automatic bus_wr_t(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_sel = 0; bus_wr = 0;
    case (a)
      3'd1: if (!m_busy) m_ptr[7:0] = d;
      3'd2: if (!m_busy) begin m_ptr[15:8] = m_ptr[15:8] | d; m_busy = 1; starts_exp++; end
      3'd7: soft_model();
      default: ;
    endcase
  endtask

  task automatic bus_rd_t(input logic [2:0] a, input string req);
    logic [7:0] d;
    @(negedge clk);
    bus_sel = 1; bus_wr = 0; bus_addr = a;
    #1 d = bus_rdata;
    chk(req, {8'h0, d}, {8'h0, exp_read(a)});
    @(posedge clk); #1;
    bus_sel = 0;
    if (a == 3'd1) m_int = 0;
  endtask

  task automatic complete(input logic [1:0] rt, input logic [7:0] e, input logic ch, input logic ir);
    @(negedge clk);
    cmp_valid = 1; cmp_rtype = rt; cmp_err = e; cmp_rdychg = ch; cmp_irq = ir;
    @(posedge clk); #1;
    cmp_valid = 0;
    if (m_busy) begin
      m_rtype = rt; m_err = e; m_chg = ch; if (ir) m_int = 1; m_busy = 0;
    end
  endtask

  task automatic check_pins(input string req);
    chk({req, " ptr"}, iopb_ptr, m_ptr);
    chk({req, " ready"}, {15'h0, cmp_ready}, {15'h0, m_busy});
    chk({req, " irq"}, {15'h0, irq}, {15'h0, m_int});
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h1D5C));
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    m_ptr = 0; m_busy = 0; soft_model();

    // R9 / R1: reset state with drive 0 ready
    check_pins("R9 reset");
    bus_rd_t(3'd0, "R1 R9 status after reset");
    bus_rd_t(3'd1, "R2 rtype after reset");
    bus_rd_t(3'd3, "R6 result after reset");

    // R3: pointer load and launch pulse
    bus_wr_t(3'd1, 8'h34);
    bus_wr_t(3'd2, 8'h12);
    chk("R3 start high", {15'h0, start_pulse}, 16'h1);
    @(posedge clk); #1;
    chk("R3 start one cycle", {15'h0, start_pulse}, 16'h0);
    check_pins("R3 launch");

    // R4: writes while busy are ignored
    bus_wr_t(3'd1, 8'hFF);
    bus_wr_t(3'd2, 8'hFF);
    @(posedge clk); #1;
    check_pins("R4 busy writes");
    chk("R4 no extra start", starts_seen, starts_exp);

    // R5 / R11 / R6 / R2
    complete(2'b00, 8'h88, 1'b1, 1'b1);
    check_pins("R5 R11 done");
    bus_rd_t(3'd0, "R11 status int bit");
    bus_rd_t(3'd3, "R6 R7 error byte");
    bus_rd_t(3'd1, "R2 rtype read");
    check_pins("R2 irq cleared");
    bus_rd_t(3'd0, "R2 status cleared");

    // R3: high byte ORs
    bus_wr_t(3'd1, 8'h0F);
    bus_wr_t(3'd2, 8'hA0);
    check_pins("R3 high OR");
    complete(2'b10, 8'h04, 1'b1, 1'b0);
    bus_rd_t(3'd3, "R6 R7 ready byte");
    check_pins("R5 no irq request");

    // R8: soft reset while busy
    bus_wr_t(3'd2, 8'h01);
    drive_rdy = 2'b11;
    bus_wr_t(3'd7, 8'h00);
    check_pins("R8 sreset busy");
    bus_rd_t(3'd0, "R8 status after sreset");
    bus_rd_t(3'd3, "R8 R7 result after sreset");
    complete(2'b01, 8'h20, 1'b0, 1'b1);
    bus_rd_t(3'd3, "R6 rtype1 no rdychg");

    // R5: idle completion offered is refused
    @(negedge clk);
    cmp_valid = 1; cmp_rtype = 2'b11; cmp_err = 8'h55; cmp_rdychg = 1; cmp_irq = 1;
    repeat (3) @(posedge clk);
    #1 cmp_valid = 0;
    check_pins("R5 idle refuse");
    bus_rd_t(3'd1, "R5 idle rtype kept");

    // R10: ignored write and zero reads
    bus_wr_t(3'd3, 8'hFF);
    bus_rd_t(3'd3, "R10 write3 ignored");
    for (int a = 2; a < 8; a++) if (a != 3) bus_rd_t(a[2:0], "R10 unused read");

    // constrained random mix
    for (int n = 0; n < 400; n++) begin
      int op = $urandom_range(0, 9);
      case (op)
        0: bus_wr_t(3'd1, 8'($urandom));
        1: bus_wr_t(3'd2, 8'($urandom));
        2: if (m_busy) complete(2'($urandom), 8'($urandom), 1'($urandom), 1'($urandom));
        3, 4, 5, 6: bus_rd_t(3'($urandom), "R1 R2 R6 R10 random read");
        7: begin bus_wr_t(3'd3, 8'($urandom)); bus_rd_t(3'd3, "R10 random write3"); end
        8: begin drive_rdy = 2'($urandom); bus_wr_t(3'd7, 8'($urandom)); end
        default: @(posedge clk);
      endcase
      #1 check_pins("R3 R4 R5 R11 random");
    end
    repeat (2) @(posedge clk);
    #1 chk("R3 R4 start count", starts_seen, starts_exp);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule